// File: doc/BRIEF.md
# DMA Channel Status and Interrupt Flags

This block holds the per-channel state bits and interrupt flags of a two-channel DMA controller. The channel engines feed it single-cycle event pulses: a block became pending, a block started, a transfer was aborted, a block finished, a whole transaction finished, an error was found, and the channel was disabled. From these pulses it keeps two live status bits per channel (busy and pending) and two sticky flags per channel (error and transaction complete). Each channel has its own interrupt request line.

Software reaches the block through a small register port with an address, a write strobe, write data and combinational read data. The flag register is cleared by writing ones. The status register can only be read. All events and writes take effect at the rising clock edge where they are sampled, and the new state is visible from the next cycle on. There is no streaming data path, so every pin is a plain level or pulse with no handshake.

Top module: `dma_stat_flags`

## Requirements
- R1: After an active-low reset, all busy, pending, error and completion bits are zero, both registers read zero and every interrupt line is low.
- R2: An error pulse on a channel sets that channel's error flag on the next edge, and the flag stays set until software clears it.
- R3: A transaction-done pulse sets the channel's completion flag. When the channel's unlimited-repeat input is high, a block-done pulse also sets it. With unlimited repeat low, block-done leaves the flag unchanged.
- R4: The flag register sits at offset 0x03. Its layout is bit 5 = channel 1 error, bit 4 = channel 0 error, bit 1 = channel 1 completion and bit 0 = channel 0 completion. Writing a one clears the flag in that position. Writing a zero leaves it unchanged. A hardware set and a clear on the same flag in the same cycle leave the flag set.
- R5: A block-start pulse sets the channel's busy bit. Busy clears on a disable pulse, an error pulse, or any event that sets the completion flag. A clearing event wins over a start in the same cycle.
- R6: A pending pulse sets the channel's pending bit. A start or abort pulse clears it, and a clear wins over a set in the same cycle.
- R7: The status register sits at offset 0x04. Its layout is bit 5 = channel 1 busy, bit 4 = channel 0 busy, bit 1 = channel 1 pending and bit 0 = channel 0 pending. Writes to it change nothing.
- R8: Bits 7:6 and 3:2 of both registers read zero, and every other offset reads zero.
- R9: A channel's interrupt line is high when its error flag is set and its error enable is high, or when its completion flag is set and its completion enable is high. The line follows the flags and enables in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_pend | input | 2 | Per channel: a block transfer became pending |
| ev_start | input | 2 | Per channel: a block transfer started |
| ev_abort | input | 2 | Per channel: the transfer was aborted |
| ev_blk_done | input | 2 | Per channel: one block finished |
| ev_xact_done | input | 2 | Per channel: the whole transaction finished |
| ev_err | input | 2 | Per channel: an error was detected |
| ev_disable | input | 2 | Per channel: the channel was disabled |
| rep_unlim | input | 2 | Per channel: unlimited repeat mode is active |
| reg_addr | input | 4 | Register offset |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| irq_en_err | input | 2 | Per channel: enable the error interrupt |
| irq_en_done | input | 2 | Per channel: enable the completion interrupt |
| irq | output | 2 | Per channel interrupt request |

## Verification
Any wrong internal bit shows up one cycle after the event that caused it. It appears on reg_rdata whenever the matching offset is addressed, and on irq when the matching enable is high. The bench therefore keeps its own model of all eight state bits and compares both registers and both interrupt lines on every clock. A bit that wrongly stays set or wrongly clears, a lost same-cycle priority, or a field moved to another bit position all appear within one cycle of being read. The bench covers the coincidences that decide priority: set against clear, start against clear, and pending against abort.

// File: rtl/dma_stat_pkg.sv
package dma_stat_pkg;
  // one bit per event kind, delivered to a single channel
  typedef struct packed {
    logic pend;
    logic start;
    logic abort;
    logic blk_done;
    logic xact_done;
    logic err;
    logic dis;
  } chan_ev_t;
endpackage

// File: rtl/dma_stat_chan.sv
module dma_stat_chan
  import dma_stat_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  chan_ev_t ev,
  input  logic     unlim,
  input  logic     clr_err,
  input  logic     clr_done,
  output logic     busy,
  output logic     pend,
  output logic     err_flag,
  output logic     done_flag
);
  logic done_set;
  logic busy_kill;
  logic pend_kill;

  assign done_set  = ev.xact_done | (unlim & ev.blk_done);
  assign busy_kill = ev.dis | ev.err | done_set;
  assign pend_kill = ev.start | ev.abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_flag  <= 1'b0;
      done_flag <= 1'b0;
      busy      <= 1'b0;
      pend      <= 1'b0;
    end else begin
      if (ev.err)       err_flag <= 1'b1;
      else if (clr_err) err_flag <= 1'b0;

      if (done_set)      done_flag <= 1'b1;
      else if (clr_done) done_flag <= 1'b0;

      if (busy_kill)     busy <= 1'b0;
      else if (ev.start) busy <= 1'b1;

      if (pend_kill)    pend <= 1'b0;
      else if (ev.pend) pend <= 1'b1;
    end
  end

  a_r2_err_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ev.err |=> err_flag);
  a_r2_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !clr_err) |=> err_flag);
  a_r3_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.xact_done || (unlim && ev.blk_done)) |=> done_flag);
  a_r4_clear_err: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_err && !ev.err) |=> !err_flag);
  a_r4_clear_done: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_done && !ev.xact_done && !(unlim && ev.blk_done)) |=> !done_flag);
  a_r5_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.dis || ev.err || ev.xact_done || (unlim && ev.blk_done)) |=> !busy);
  a_r5_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.start && !ev.dis && !ev.err && !ev.xact_done && !(unlim && ev.blk_done)) |=> busy);
  a_r6_pend_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.start || ev.abort) |=> !pend);
  a_r6_pend_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.pend && !ev.start && !ev.abort) |=> pend);
endmodule

// File: rtl/dma_stat_regif.sv
module dma_stat_regif #(
  parameter int unsigned NCH       = 2,
  parameter int unsigned AW        = 4,
  parameter int unsigned DW        = 8,
  parameter int unsigned HI_BASE   = 4,
  parameter logic [AW-1:0] OFS_FLAGS = 4'h3,
  parameter logic [AW-1:0] OFS_STAT  = 4'h4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  addr,
  input  logic           we,
  input  logic [DW-1:0]  wdata,
  input  logic [NCH-1:0] err_flag,
  input  logic [NCH-1:0] done_flag,
  input  logic [NCH-1:0] busy,
  input  logic [NCH-1:0] pend,
  output logic [DW-1:0]  rdata,
  output logic [NCH-1:0] clr_err,
  output logic [NCH-1:0] clr_done
);
  logic hit_flags;
  logic hit_stat;

  assign hit_flags = (addr == OFS_FLAGS);
  assign hit_stat  = (addr == OFS_STAT);

  assign clr_err  = (we && hit_flags) ? wdata[HI_BASE +: NCH] : '0;
  assign clr_done = (we && hit_flags) ? wdata[NCH-1:0]        : '0;

  always_comb begin
    rdata = '0;
    if (hit_flags) begin
      rdata[HI_BASE +: NCH] = err_flag;
      rdata[NCH-1:0]        = done_flag;
    end else if (hit_stat) begin
      rdata[HI_BASE +: NCH] = busy;
      rdata[NCH-1:0]        = pend;
    end
  end

  a_r4_no_clear_off_target: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && hit_flags) |-> (clr_err == '0 && clr_done == '0));
endmodule

// File: rtl/dma_stat_flags.sv
module dma_stat_flags
  import dma_stat_pkg::*;
#(
  parameter int unsigned NCH     = 2,
  parameter int unsigned AW      = 4,
  parameter int unsigned DW      = 8,
  parameter int unsigned HI_BASE = 4,
  parameter logic [AW-1:0] OFS_FLAGS = 4'h3,
  parameter logic [AW-1:0] OFS_STAT  = 4'h4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] ev_pend,
  input  logic [NCH-1:0] ev_start,
  input  logic [NCH-1:0] ev_abort,
  input  logic [NCH-1:0] ev_blk_done,
  input  logic [NCH-1:0] ev_xact_done,
  input  logic [NCH-1:0] ev_err,
  input  logic [NCH-1:0] ev_disable,
  input  logic [NCH-1:0] rep_unlim,
  input  logic [AW-1:0]  reg_addr,
  input  logic           reg_we,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  input  logic [NCH-1:0] irq_en_err,
  input  logic [NCH-1:0] irq_en_done,
  output logic [NCH-1:0] irq
);
  logic [NCH-1:0] err_flag;
  logic [NCH-1:0] done_flag;
  logic [NCH-1:0] busy;
  logic [NCH-1:0] pend;
  logic [NCH-1:0] clr_err;
  logic [NCH-1:0] clr_done;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    chan_ev_t ev;
    assign ev = '{pend:      ev_pend[c],
                  start:     ev_start[c],
                  abort:     ev_abort[c],
                  blk_done:  ev_blk_done[c],
                  xact_done: ev_xact_done[c],
                  err:       ev_err[c],
                  dis:       ev_disable[c]};

    dma_stat_chan u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev        (ev),
      .unlim     (rep_unlim[c]),
      .clr_err   (clr_err[c]),
      .clr_done  (clr_done[c]),
      .busy      (busy[c]),
      .pend      (pend[c]),
      .err_flag  (err_flag[c]),
      .done_flag (done_flag[c])
    );

    assign irq[c] = (err_flag[c] & irq_en_err[c]) | (done_flag[c] & irq_en_done[c]);

    a_r9_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_err[c] && irq_en_err[c]) |=> (irq[c] || !$stable(irq_en_err[c])));
  end

  dma_stat_regif #(
    .NCH(NCH), .AW(AW), .DW(DW), .HI_BASE(HI_BASE),
    .OFS_FLAGS(OFS_FLAGS), .OFS_STAT(OFS_STAT)
  ) u_regif (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (reg_addr),
    .we        (reg_we),
    .wdata     (reg_wdata),
    .err_flag  (err_flag),
    .done_flag (done_flag),
    .busy      (busy),
    .pend      (pend),
    .rdata     (reg_rdata),
    .clr_err   (clr_err),
    .clr_done  (clr_done)
  );

  a_r7_status_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == OFS_STAT && ev_err == '0 && ev_xact_done == '0 && ev_blk_done == '0)
      |=> (err_flag == $past(err_flag) && done_flag == $past(done_flag)));
endmodule

// File: tb/tb_dma_stat_flags.sv
module tb_dma_stat_flags;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] ev_pend, ev_start, ev_abort, ev_blk_done, ev_xact_done, ev_err, ev_disable;
  logic [1:0] rep_unlim, irq_en_err, irq_en_done, irq;
  logic [3:0] reg_addr;
  logic       reg_we;
  logic [7:0] reg_wdata, reg_rdata;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  // reference model state
  int m_err[2], m_done[2], m_busy[2], m_pend[2];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_stat_flags dut (
    .clk(clk), .rst_n(rst_n),
    .ev_pend(ev_pend), .ev_start(ev_start), .ev_abort(ev_abort),
    .ev_blk_done(ev_blk_done), .ev_xact_done(ev_xact_done),
    .ev_err(ev_err), .ev_disable(ev_disable), .rep_unlim(rep_unlim),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_en_err(irq_en_err),
    .irq_en_done(irq_en_done), .irq(irq)
  );

  function automatic logic [7:0] exp_rdata();
    logic [7:0] v = 8'h00;
    if (reg_addr == 4'h3) begin
      v[5] = m_err[1][0];  v[4] = m_err[0][0];
      v[1] = m_done[1][0]; v[0] = m_done[0][0];
    end else if (reg_addr == 4'h4) begin
      v[5] = m_busy[1][0]; v[4] = m_busy[0][0];
      v[1] = m_pend[1][0]; v[0] = m_pend[0][0];
    end
    return v;
  endfunction

  function automatic logic [1:0] exp_irq();
    logic [1:0] v;
    for (int c = 0; c < 2; c++)
      v[c] = (m_err[c][0] & irq_en_err[c]) | (m_done[c][0] & irq_en_done[c]);
    return v;
  endfunction

  task automatic compare(string tag);
    total++;
    if (reg_rdata !== exp_rdata()) begin
      bad++;
      $display("FAIL %s rdata addr=%0h actual=%02h expected=%02h", tag, reg_addr, reg_rdata, exp_rdata());
    end
    total++;
    if (irq !== exp_irq()) begin
      bad++;
      $display("FAIL %s R9 irq actual=%b expected=%b", tag, irq, exp_irq());
    end
  endtask

  task automatic model_step();
    for (int c = 0; c < 2; c++) begin
      int dset = ev_xact_done[c] | (rep_unlim[c] & ev_blk_done[c]);
      int ce   = reg_we && reg_addr == 4'h3 && reg_wdata[4+c];
      int cd   = reg_we && reg_addr == 4'h3 && reg_wdata[c];
      if (ev_err[c]) m_err[c] = 1; else if (ce) m_err[c] = 0;
      if (dset) m_done[c] = 1; else if (cd) m_done[c] = 0;
      if (ev_disable[c] || ev_err[c] || dset) m_busy[c] = 0;
      else if (ev_start[c]) m_busy[c] = 1;
      if (ev_start[c] || ev_abort[c]) m_pend[c] = 0;
      else if (ev_pend[c]) m_pend[c] = 1;
    end
  endtask

  // called at a negedge with inputs set; returns at the next negedge
  task automatic cycle(string tag);
    #1 compare(tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic idle_in();
    ev_pend = 0; ev_start = 0; ev_abort = 0; ev_blk_done = 0;
    ev_xact_done = 0; ev_err = 0; ev_disable = 0; reg_we = 0; reg_wdata = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!ended) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 2; c++) begin m_err[c]=0; m_done[c]=0; m_busy[c]=0; m_pend[c]=0; end
    idle_in();
    rep_unlim = 0; irq_en_err = 2'b11; irq_en_done = 2'b11; reg_addr = 4'h3;
    rst_n = 0;
    ev_err = 2'b11; ev_start = 2'b11;     // events during reset must not stick
    repeat (3) @(negedge clk);
    #1 compare("R1 flags in reset");
    reg_addr = 4'h4; #1 compare("R1 status in reset");
    idle_in();
    rst_n = 1;
    @(negedge clk);
    cycle("R1 after reset");

    // pending set, then start clears it and sets busy
    ev_pend = 2'b01; cycle("R6 pend set");
    idle_in();        cycle("R6 pend visible");
    ev_start = 2'b01; cycle("R5 R6 start");
    idle_in();        cycle("R5 busy visible");
    ev_pend = 2'b10; ev_abort = 2'b10; cycle("R6 abort beats pend");
    idle_in();        cycle("R6 pend stays low");
    ev_pend = 2'b10;  cycle("R6 pend ch1");
    ev_pend = 0; ev_abort = 2'b10; cycle("R6 abort clears");
    idle_in();        cycle("R6 after abort");

    // completion clears busy
    ev_xact_done = 2'b01; cycle("R3 xact done");
    idle_in();        cycle("R5 busy cleared by completion");
    reg_addr = 4'h3;  cycle("R3 done flag read");
    ev_err = 2'b10;   cycle("R2 error ch1");
    idle_in();        cycle("R2 error visible");
    irq_en_err = 2'b00; cycle("R9 error irq masked");
    irq_en_done = 2'b10; cycle("R9 done irq masked");
    irq_en_err = 2'b11; irq_en_done = 2'b11;

    // unlimited repeat
    reg_we = 1; reg_wdata = 8'h33; cycle("R4 clear all");
    idle_in();        cycle("R4 cleared");
    rep_unlim = 2'b01; ev_blk_done = 2'b11; cycle("R3 block done");
    idle_in();        cycle("R3 only repeat channel set");
    rep_unlim = 2'b00; ev_blk_done = 2'b01; reg_we = 1; reg_wdata = 8'h01;
    cycle("R3 R4 block done without repeat, cleared");
    idle_in();        cycle("R3 no set without repeat");

    // write-zero keeps, set beats clear
    ev_err = 2'b01; ev_xact_done = 2'b10; cycle("R2 R3 set");
    idle_in(); reg_we = 1; reg_wdata = 8'h00; cycle("R4 write zero");
    idle_in(); reg_we = 1; reg_wdata = 8'hCC; cycle("R4 reserved ones");
    idle_in(); reg_we = 1; reg_wdata = 8'h33; ev_err = 2'b01; cycle("R4 set wins");
    idle_in();        cycle("R4 after set wins");

    // status register is read only
    ev_start = 2'b10; ev_pend = 2'b01; cycle("R5 R6 ch1 start, ch0 pend");
    idle_in(); reg_addr = 4'h4; reg_we = 1; reg_wdata = 8'hFF; cycle("R7 write status");
    idle_in();        cycle("R7 status unchanged");
    reg_addr = 4'h3; cycle("R7 flags unchanged");
    ev_start = 2'b10; ev_disable = 2'b10; reg_addr = 4'h4; cycle("R5 disable beats start");
    idle_in();        cycle("R5 after disable");
    ev_start = 2'b01; cycle("R5 ch0 start");
    ev_start = 2'b00; ev_disable = 2'b01; cycle("R5 disable");
    idle_in();        cycle("R5 after disable ch0");

    // other offsets
    reg_addr = 4'h0; cycle("R8 offset 0");
    reg_addr = 4'h5; cycle("R8 offset 5");
    reg_addr = 4'hF; cycle("R8 offset 15");

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      int a = $urandom_range(0, 9);
      ev_pend      = 2'($urandom_range(0, 3) == 0 ? $urandom : 0);
      ev_start     = 2'($urandom_range(0, 3) == 0 ? $urandom : 0);
      ev_abort     = 2'($urandom_range(0, 7) == 0 ? $urandom : 0);
      ev_blk_done  = 2'($urandom_range(0, 3) == 0 ? $urandom : 0);
      ev_xact_done = 2'($urandom_range(0, 7) == 0 ? $urandom : 0);
      ev_err       = 2'($urandom_range(0, 9) == 0 ? $urandom : 0);
      ev_disable   = 2'($urandom_range(0, 9) == 0 ? $urandom : 0);
      rep_unlim    = 2'($urandom);
      irq_en_err   = 2'($urandom);
      irq_en_done  = 2'($urandom);
      reg_addr     = (a < 4) ? 4'h3 : (a < 8) ? 4'h4 : 4'($urandom);
      reg_we       = ($urandom_range(0, 3) == 0);
      reg_wdata    = 8'($urandom);
      cycle("R2 R3 R4 R5 R6 R7 R8 R9 random");
    end

    ended = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule